// File: doc/BRIEF.md
# Crypto packet descriptor decoder

This block sits at the front of a packet-security pipeline. On each start-of-packet strobe it takes the raw per-packet security parameters (crypto mode, cipher-suite code, confidentiality offset, security-association index and the replay-protection request) and produces a normalized descriptor for the stages downstream. The descriptor gives the key length, whether 64-bit packet numbering is in use, whether the key comes from on-chip storage or from the externally supplied key, the channel number that owns the association, an offset cleaned of values the mode forbids, the effective replay-protection enable, and a flag for settings the mode does not allow.

Every descriptor field is registered. The fields update one clock after the strobe, and a one-cycle valid pulse marks them. Between strobes the fields keep their last value. The number of associations per channel is a build-time parameter. It selects which slice of the index forms the channel number.

Mode codes on `mode_i`: 0 = MACsec, 1 = IPsec, 2 = bulk authenticated encryption, 3 = bulk block mode. Codes 2 and 3 together are called the bulk modes.

Top module: `sec_desc_decoder`

## Requirements
- R1: `desc_vld_o` is high in exactly the cycle after a cycle in which `sop_i` was high and `rst` low, and low in every other cycle.
- R2: Outside the bulk modes, suite code 0 gives `key256_o`=0, `xpn_o`=0; code 1 gives 1,0; code 2 gives 0,1; code 3 gives 1,1. In the bulk modes codes 0 and 1 map in the same way, and `illegal_o` is 0 for every legal code.
- R3: In a bulk mode, suite code 2 or 3 sets `illegal_o`=1 and forces `key256_o`=0 and `xpn_o`=0.
- R4: In MACsec mode an offset of 0, 30 or 50 is passed to `offset_o` unchanged, and every other offset gives 0.
- R5: In either bulk mode any offset from 0 to 63 is passed to `offset_o` unchanged.
- R6: In IPsec mode `offset_o` is 0 whatever the offset input.
- R7: `ext_key_o` is 1 when the index is 1024 or more and 0 for indices 0 to 1023.
- R8: `chan_o` is the index with its low log2(SAS_PER_CHAN) bits dropped: bits [19:1] when there are two associations per channel, bits [19:2] when there are four.
- R9: `replay_o` follows `replay_en_i` in MACsec and IPsec modes and is 0 in both bulk modes.
- R10: A synchronous reset clears all outputs to 0. While no descriptor is being produced, every descriptor field holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sop_i | input | 1 | Start-of-packet strobe that qualifies the parameter inputs |
| mode_i | input | 2 | Crypto mode code |
| suite_i | input | 2 | Cipher-suite code |
| offset_i | input | OFF_W (6) | Raw confidentiality offset in bytes |
| sa_idx_i | input | IDX_W (20) | Security-association index |
| replay_en_i | input | 1 | Replay-protection request |
| desc_vld_o | output | 1 | One-cycle pulse marking a new descriptor |
| key256_o | output | 1 | 1 = 256-bit key, 0 = 128-bit key |
| xpn_o | output | 1 | 64-bit packet numbering in use |
| illegal_o | output | 1 | Suite code not allowed in the current mode |
| ext_key_o | output | 1 | Use the externally supplied key instead of on-chip storage |
| chan_o | output | CHAN_W (19) | Channel number derived from the index |
| offset_o | output | OFF_W (6) | Sanitized confidentiality offset |
| replay_o | output | 1 | Effective replay-protection enable |

## Verification
Directed packets run all four suite codes under every mode. This separates the plain suite mapping from the bulk-mode rejection of codes 2 and 3. Offsets of 0, 29, 30, 31, 50, 51 and 63 are applied under each mode, which shows the MACsec whitelist, bulk pass-through and IPsec zeroing apart. Indices of 0, 1, 1023, 1024 and the all-ones value probe the internal/external boundary and the channel slicing, on a second instance built with four associations per channel. Back-to-back strobes, gaps with changing inputs, and a long randomized run complete the coverage. They check that a descriptor is produced only one cycle after a strobe and that the fields hold while the inputs move.

// File: rtl/sdd_pkg.sv
package sdd_pkg;

  typedef enum logic [1:0] {
    MODE_MACSEC     = 2'd0,
    MODE_IPSEC      = 2'd1,
    MODE_BULK_AEAD  = 2'd2,
    MODE_BULK_BLOCK = 2'd3
  } crypto_mode_e;

  typedef struct packed {
    logic key256;
    logic xpn;
    logic illegal;
  } suite_dec_t;

  function automatic logic is_bulk(crypto_mode_e m);
    return (m == MODE_BULK_AEAD) || (m == MODE_BULK_BLOCK);
  endfunction

endpackage

// File: rtl/sdd_suite_dec.sv
module sdd_suite_dec
  import sdd_pkg::*;
(
  input  crypto_mode_e mode,
  input  logic [1:0]   suite,
  output suite_dec_t   dec
);

  logic bulk;
  logic ext_pn_code;

  assign bulk        = is_bulk(mode);
  assign ext_pn_code = suite[1];

  always_comb begin
    dec.key256  = suite[0];
    dec.xpn     = ext_pn_code;
    dec.illegal = 1'b0;
    if (bulk && ext_pn_code) begin
      // extended numbering is not defined for the bulk modes
      dec.key256  = 1'b0;
      dec.xpn     = 1'b0;
      dec.illegal = 1'b1;
    end
  end

endmodule

// File: rtl/sdd_offset_clean.sv
module sdd_offset_clean
  import sdd_pkg::*;
#(
  parameter int OFF_W     = 6,
  parameter int MAC_OFF_A = 30,
  parameter int MAC_OFF_B = 50
) (
  input  crypto_mode_e     mode,
  input  logic [OFF_W-1:0] off_in,
  output logic [OFF_W-1:0] off_out
);

  localparam logic [OFF_W-1:0] OFF_A = OFF_W'(MAC_OFF_A);
  localparam logic [OFF_W-1:0] OFF_B = OFF_W'(MAC_OFF_B);

  logic mac_ok;

  assign mac_ok = (off_in == '0) || (off_in == OFF_A) || (off_in == OFF_B);

  always_comb begin
    unique case (mode)
      MODE_MACSEC:     off_out = mac_ok ? off_in : '0;
      MODE_IPSEC:      off_out = '0;
      MODE_BULK_AEAD,
      MODE_BULK_BLOCK: off_out = off_in;
      default:         off_out = '0;
    endcase
  end

endmodule

// File: rtl/sdd_sa_split.sv
module sdd_sa_split #(
  parameter int IDX_W        = 20,
  parameter int INT_SA_COUNT = 1024,
  parameter int SAS_PER_CHAN = 2,
  parameter int CHAN_W       = IDX_W - $clog2(SAS_PER_CHAN)
) (
  input  logic [IDX_W-1:0]  sa_idx,
  output logic              ext_key,
  output logic [CHAN_W-1:0] chan
);

  localparam int SA_SHIFT = $clog2(SAS_PER_CHAN);
  localparam logic [IDX_W-1:0] INT_LIMIT = IDX_W'(INT_SA_COUNT);

  assign ext_key = (sa_idx >= INT_LIMIT);

  generate
    if (SA_SHIFT == 0) begin : g_one_sa
      assign chan = sa_idx;
    end else begin : g_multi_sa
      assign chan = sa_idx[IDX_W-1:SA_SHIFT];
    end
  endgenerate

endmodule

// File: rtl/sec_desc_decoder.sv
module sec_desc_decoder
  import sdd_pkg::*;
#(
  parameter int IDX_W        = 20,
  parameter int OFF_W        = 6,
  parameter int INT_SA_COUNT = 1024,
  parameter int SAS_PER_CHAN = 2,
  parameter int CHAN_W       = IDX_W - $clog2(SAS_PER_CHAN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sop_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        suite_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [IDX_W-1:0]  sa_idx_i,
  input  logic              replay_en_i,
  output logic              desc_vld_o,
  output logic              key256_o,
  output logic              xpn_o,
  output logic              illegal_o,
  output logic              ext_key_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [OFF_W-1:0]  offset_o,
  output logic              replay_o
);

  crypto_mode_e      mode;
  suite_dec_t        suite_d;
  logic [OFF_W-1:0]  off_d;
  logic              ext_d;
  logic [CHAN_W-1:0] chan_d;
  logic              replay_d;

  assign mode     = crypto_mode_e'(mode_i);
  assign replay_d = replay_en_i & ~is_bulk(mode);

  sdd_suite_dec u_suite (
    .mode  (mode),
    .suite (suite_i),
    .dec   (suite_d)
  );

  sdd_offset_clean #(
    .OFF_W (OFF_W)
  ) u_off (
    .mode    (mode),
    .off_in  (offset_i),
    .off_out (off_d)
  );

  sdd_sa_split #(
    .IDX_W        (IDX_W),
    .INT_SA_COUNT (INT_SA_COUNT),
    .SAS_PER_CHAN (SAS_PER_CHAN),
    .CHAN_W       (CHAN_W)
  ) u_sa (
    .sa_idx  (sa_idx_i),
    .ext_key (ext_d),
    .chan    (chan_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_vld_o <= 1'b0;
      key256_o   <= 1'b0;
      xpn_o      <= 1'b0;
      illegal_o  <= 1'b0;
      ext_key_o  <= 1'b0;
      chan_o     <= '0;
      offset_o   <= '0;
      replay_o   <= 1'b0;
    end else begin
      desc_vld_o <= sop_i;
      if (sop_i) begin
        key256_o  <= suite_d.key256;
        xpn_o     <= suite_d.xpn;
        illegal_o <= suite_d.illegal;
        ext_key_o <= ext_d;
        chan_o    <= chan_d;
        offset_o  <= off_d;
        replay_o  <= replay_d;
      end
    end
  end

endmodule

// File: rtl/sdd_checker.sv
module sdd_checker #(
  parameter int IDX_W        = 20,
  parameter int OFF_W        = 6,
  parameter int INT_SA_COUNT = 1024,
  parameter int CHAN_W       = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              sop_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        suite_i,
  input logic [OFF_W-1:0]  offset_i,
  input logic [IDX_W-1:0]  sa_idx_i,
  input logic              replay_en_i,
  input logic              desc_vld_o,
  input logic              key256_o,
  input logic              xpn_o,
  input logic              illegal_o,
  input logic              ext_key_o,
  input logic [CHAN_W-1:0] chan_o,
  input logic [OFF_W-1:0]  offset_o,
  input logic              replay_o
);

  logic warm_q;
  always_ff @(posedge clk) begin
    if (rst) warm_q <= 1'b0;
    else     warm_q <= 1'b1;
  end

  p_vld_after_sop_r1: assert property (@(posedge clk) disable iff (rst)
    sop_i |=> desc_vld_o);
  p_no_vld_without_sop_r1: assert property (@(posedge clk) disable iff (rst)
    !sop_i |=> !desc_vld_o);

  p_suite_map_r2: assert property (@(posedge clk) disable iff (rst)
    (desc_vld_o && !$past(mode_i[1])) |->
      (key256_o == $past(suite_i[0])) && (xpn_o == $past(suite_i[1])) && !illegal_o);

  p_bulk_illegal_r3: assert property (@(posedge clk) disable iff (rst)
    (desc_vld_o && $past(mode_i[1]) && $past(suite_i[1])) |->
      illegal_o && !key256_o && !xpn_o);

  p_macsec_offset_r4: assert property (@(posedge clk) disable iff (rst)
    (desc_vld_o && ($past(mode_i) == 2'd0)) |->
      (offset_o == 0) || (offset_o == OFF_W'(30)) || (offset_o == OFF_W'(50)));

  p_bulk_offset_r5: assert property (@(posedge clk) disable iff (rst)
    (desc_vld_o && $past(mode_i[1])) |-> (offset_o == $past(offset_i)));

  p_ipsec_offset_r6: assert property (@(posedge clk) disable iff (rst)
    (desc_vld_o && ($past(mode_i) == 2'd1)) |-> (offset_o == '0));

  p_ext_key_r7: assert property (@(posedge clk) disable iff (rst)
    desc_vld_o |-> (ext_key_o == ($past(sa_idx_i) >= IDX_W'(INT_SA_COUNT))));

  p_chan_slice_r8: assert property (@(posedge clk) disable iff (rst)
    desc_vld_o |-> (chan_o == $past(sa_idx_i[IDX_W-1:IDX_W-CHAN_W])));

  p_replay_bulk_r9: assert property (@(posedge clk) disable iff (rst)
    (desc_vld_o && $past(mode_i[1])) |-> !replay_o);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (warm_q && !desc_vld_o) |->
      $stable({key256_o, xpn_o, illegal_o, ext_key_o, chan_o, offset_o, replay_o}));

endmodule

bind sec_desc_decoder sdd_checker #(
  .IDX_W        (IDX_W),
  .OFF_W        (OFF_W),
  .INT_SA_COUNT (INT_SA_COUNT),
  .CHAN_W       (CHAN_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sop_i       (sop_i),
  .mode_i      (mode_i),
  .suite_i     (suite_i),
  .offset_i    (offset_i),
  .sa_idx_i    (sa_idx_i),
  .replay_en_i (replay_en_i),
  .desc_vld_o  (desc_vld_o),
  .key256_o    (key256_o),
  .xpn_o       (xpn_o),
  .illegal_o   (illegal_o),
  .ext_key_o   (ext_key_o),
  .chan_o      (chan_o),
  .offset_o    (offset_o),
  .replay_o    (replay_o)
);

// File: tb/test_sec_desc_decoder.sv
module test_sec_desc_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sop = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [1:0]  suite = 2'd0;
  logic [5:0]  off = 6'd0;
  logic [19:0] idx = 20'd0;
  logic        rpl = 1'b0;

  logic        vld, k256, xpn, ill, ext, rep;
  logic [18:0] chan;
  logic [5:0]  offo;
  logic        vld4, k2564, xpn4, ill4, ext4, rep4;
  logic [17:0] chan4;
  logic [5:0]  offo4;

  int vectors = 0;
  int miscmp  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  always #5ns clk = ~clk;

  sec_desc_decoder i_sec_desc_decoder (
    .clk(clk), .rst(rst), .sop_i(sop), .mode_i(mode), .suite_i(suite),
    .offset_i(off), .sa_idx_i(idx), .replay_en_i(rpl),
    .desc_vld_o(vld), .key256_o(k256), .xpn_o(xpn), .illegal_o(ill),
    .ext_key_o(ext), .chan_o(chan), .offset_o(offo), .replay_o(rep));

  sec_desc_decoder #(.SAS_PER_CHAN(4)) i_sec_desc_decoder_q4 (
    .clk(clk), .rst(rst), .sop_i(sop), .mode_i(mode), .suite_i(suite),
    .offset_i(off), .sa_idx_i(idx), .replay_en_i(rpl),
    .desc_vld_o(vld4), .key256_o(k2564), .xpn_o(xpn4), .illegal_o(ill4),
    .ext_key_o(ext4), .chan_o(chan4), .offset_o(offo4), .replay_o(rep4));

  // behavioural reference state
  logic        e_vld, e_k256, e_xpn, e_ill, e_ext, e_rep;
  logic [5:0]  e_off;
  int          e_idx;
  logic [1:0]  e_mode;
  bit          e_fresh;

  always @(posedge clk) begin
    if (rst) begin
      e_vld <= 0; e_k256 <= 0; e_xpn <= 0; e_ill <= 0; e_ext <= 0;
      e_rep <= 0; e_off <= 0; e_idx <= 0; e_mode <= 0; e_fresh <= 0;
    end else begin
      e_vld <= sop;
      if (sop) begin
        e_fresh <= 1;
        e_mode  <= mode;
        e_idx   <= int'(idx);
        e_ext   <= (int'(idx) > 1023);
        e_rep   <= (mode < 2) ? rpl : 1'b0;
        if (mode >= 2 && suite >= 2) begin
          e_ill <= 1; e_k256 <= 0; e_xpn <= 0;
        end else begin
          e_ill <= 0;
          e_k256 <= (suite == 1 || suite == 3);
          e_xpn  <= (suite >= 2);
        end
        if (mode == 0)      e_off <= (off == 30 || off == 50) ? off : 6'd0;
        else if (mode == 1) e_off <= 6'd0;
        else                e_off <= off;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input string fld,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscmp++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
               tag, fld, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    string t_off, t_fn;
    bit    live;
    live  = e_vld && !rst;
    t_fn  = live ? "" : "R10";
    t_off = !live ? "R10" : (e_mode == 0) ? "R4" : (e_mode == 1) ? "R6" : "R5";
    chk(vld == e_vld, "R1", "desc_vld", int'(vld), int'(e_vld));
    chk(k256 == e_k256, live ? ((e_mode >= 2) ? "R3" : "R2") : t_fn, "key256",
        int'(k256), int'(e_k256));
    chk(xpn == e_xpn, live ? ((e_mode >= 2) ? "R3" : "R2") : t_fn, "xpn",
        int'(xpn), int'(e_xpn));
    chk(ill == e_ill, live ? "R3" : t_fn, "illegal", int'(ill), int'(e_ill));
    chk(offo == e_off, t_off, "offset", int'(offo), int'(e_off));
    chk(ext == e_ext, live ? "R7" : t_fn, "ext_key", int'(ext), int'(e_ext));
    chk(int'(chan) == (e_idx >> 1), live ? "R8" : t_fn, "chan(2/ch)",
        int'(chan), e_idx >> 1);
    chk(int'(chan4) == (e_idx >> 2), live ? "R8" : t_fn, "chan(4/ch)",
        int'(chan4), e_idx >> 2);
    chk(rep == e_rep, live ? "R9" : t_fn, "replay", int'(rep), int'(e_rep));
    chk(vld4 == e_vld && offo4 == e_off && ext4 == e_ext && rep4 == e_rep
        && k2564 == e_k256 && xpn4 == e_xpn && ill4 == e_ill,
        live ? "R8" : t_fn, "q4 fields", int'(offo4), int'(e_off));
    if (!e_fresh) chk(offo == 0 && chan == 0 && !k256, "R10", "reset value",
                      int'(offo), 0);
  endtask

  // one cycle: compare away from the edge, then drive the next inputs
  task automatic step(input bit s, input logic [1:0] m, input logic [1:0] su,
                      input logic [5:0] o, input logic [19:0] ix, input bit r);
    @(negedge clk);
    compare_all();
    sop = s; mode = m; suite = su; off = o; idx = ix; rpl = r;
  endtask

  always @(posedge clk) cycles++;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscmp++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end

  initial begin
    logic [5:0] offs [7];
    logic [19:0] idxs [5];
    offs = '{6'd0, 6'd29, 6'd30, 6'd31, 6'd50, 6'd51, 6'd63};
    idxs = '{20'd0, 20'd1, 20'd1023, 20'd1024, 20'hFFFFF};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state (R10)
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    // every mode x suite, back to back (R1, R2, R3)
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        step(1, 2'(m), 2'(s), 6'd0, 20'(m * 4 + s), 1);
    // offsets under each mode (R4, R5, R6)
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 7; k++) begin
        step(1, 2'(m), 2'd0, offs[k], 20'd5, 0);
        step(0, 2'(3 - m), 2'd3, ~offs[k], 20'hABCDE, 1);  // gap: inputs move (R10)
      end
    // index boundaries (R7, R8) and replay per mode (R9)
    for (int k = 0; k < 5; k++)
      for (int m = 0; m < 4; m++)
        step(1, 2'(m), 2'd1, 6'd50, idxs[k], 1);
    step(0, 0, 0, 0, 0, 0);
    // mid-run reset (R10)
    step(1, 2'd2, 2'd1, 6'd40, 20'd77777, 1);
    @(negedge clk); compare_all(); rst = 1'b1; sop = 0;
    @(negedge clk); compare_all();
    @(negedge clk); compare_all(); rst = 1'b0;
    // randomized traffic
    for (int n = 0; n < 3000; n++)
      step(1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           2'($urandom_range(0, 3)), 6'($urandom_range(0, 63)),
           20'($urandom_range(0, 1048575)), 1'($urandom_range(0, 1)));
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule